// File: doc/BRIEF.md
# Address breakpoint match unit

This block holds a breakpoint address and watches the memory references of a processor that executes either instruction-set code (macro mode) or microcode (micro mode). When the selected condition is met, it emits a one-cycle request. That request either halts the processor or is delivered to it as an interrupt. The halt and the interrupt service are handled elsewhere.

Three inputs come from a control word and set the behaviour:

- The mode select (control bit 19) picks which reference stream is watched.
- The two-bit type select (control bits 17:16) says which references count. Its meaning changes with the mode.
- The interrupt select (control bit 18) turns a hit into an interrupt request instead of a stop request.

Macro references arrive as a 16-bit address with two qualifiers: instruction fetch and operand store. Micro references arrive as a 4-bit page, an 8-bit word address and an upper/lower half-word select. The breakpoint register loads through a write port and is cleared by master clear.

Top module: `bpm_unit`

## Requirements
- R1: The breakpoint register is zero after reset. A write stores `bp_wr_data_i` at the clock edge. The stored value appears on `bp_addr_o` from the next cycle on.
- R2: Master clear zeroes the register at the next edge and wins over a write in the same cycle. A reference strobed in a master-clear cycle produces no pulse.
- R3: With `micro_sel_i`=1 only micro strobes are considered. With `micro_sel_i`=0 only macro strobes are considered. A strobe on the other stream produces no pulse.
- R4: In macro mode the type select means:
  - 00: nothing fires.
  - 01: only a strobe with `mac_fetch_i`=1 qualifies.
  - 10: only a strobe with `mac_store_i`=1 qualifies.
  - 11: every macro strobe qualifies.
- R5: A macro hit requires all 16 register bits to equal `mac_addr_i`.
- R6: In micro mode with type 01, register bits [12:0] must equal {`mic_half_i`, `mic_page_i`, `mic_word_i`]. The half select is bit 12, the page is bits 11:8 and the word is bits 7:0. Register bits 15:13 are ignored.
- R7: In micro mode with type 10 or 11, only register bits [11:0] are compared, against {page, word}. The half select and register bits 15:12 are ignored. In micro mode, type 00 fires nothing.
- R8: Each qualifying strobe cycle produces exactly one pulse, one cycle after the strobe. The compare uses the register value held before any write in that same cycle.
- R9: With `irq_sel_i`=1 a hit pulses `irq_o` instead of `stop_o`. The two outputs are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mclr_i | input | 1 | Synchronous master clear |
| bp_wr_en_i | input | 1 | Breakpoint register write enable |
| bp_wr_data_i | input | 16 | Breakpoint register write data |
| micro_sel_i | input | 1 | 1 = micro breakpoint, 0 = macro breakpoint |
| bp_type_i | input | 2 | Breakpoint type select |
| irq_sel_i | input | 1 | 1 = interrupt request instead of stop |
| mac_vld_i | input | 1 | Macro reference strobe |
| mac_fetch_i | input | 1 | Macro reference is an instruction fetch |
| mac_store_i | input | 1 | Macro reference is an operand store |
| mac_addr_i | input | 16 | Macro memory address |
| mic_vld_i | input | 1 | Micro reference strobe |
| mic_page_i | input | 4 | Micro page field |
| mic_word_i | input | 8 | Micro word address |
| mic_half_i | input | 1 | Upper/lower half-word select |
| bp_addr_o | output | 16 | Current breakpoint register value |
| stop_o | output | 1 | Stop request pulse |
| irq_o | output | 1 | Interrupt request pulse |

## Verification
The properties assume that the control selects are steady in the cycle a strobe is sampled. They also assume that master clear behaves as an ordinary synchronous input, so that a hit and a clear may share a cycle. The stimulus changes mode, type and interrupt select only in cycles without a strobe. It deliberately places a write, and separately a master clear, in the same cycle as a matching strobe, to probe the old-value and suppression rules. Macro strobes in micro mode, and micro strobes in macro mode, are driven with addresses that would otherwise match, so that a wrongly taken path shows at the outputs.

// File: rtl/bpm_pkg.sv
package bpm_pkg;
  typedef enum logic [1:0] {
    BPT_NONE = 2'b00,
    BPT_LOW  = 2'b01,  // macro: fetch only / micro: word + half compare
    BPT_MID  = 2'b10,  // macro: store only / micro: word compare
    BPT_ALL  = 2'b11   // macro: any reference / micro: word compare
  } bp_type_e;
endpackage

// File: rtl/bpm_addr_reg.sv
module bpm_addr_reg #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         mclr_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_q <= '0;
    else if (mclr_i)  q_q <= '0;
    else if (wr_en_i) q_q <= wr_data_i;
  end

  assign q_o = q_q;
endmodule

// File: rtl/bpm_macro_cmp.sv
module bpm_macro_cmp
  import bpm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         en_i,
  input  bp_type_e     type_i,
  input  logic         vld_i,
  input  logic         fetch_i,
  input  logic         store_i,
  input  logic [W-1:0] addr_i,
  input  logic [W-1:0] bp_i,
  output logic         hit_o
);
  logic kind_ok;

  always_comb begin
    unique case (type_i)
      BPT_LOW: kind_ok = fetch_i;
      BPT_MID: kind_ok = store_i;
      BPT_ALL: kind_ok = 1'b1;
      default: kind_ok = 1'b0;
    endcase
  end

  assign hit_o = en_i && vld_i && kind_ok && (addr_i == bp_i);
endmodule

// File: rtl/bpm_micro_cmp.sv
module bpm_micro_cmp
  import bpm_pkg::*;
#(
  parameter int W      = 16,
  parameter int PAGE_W = 4,
  parameter int WORD_W = 8
) (
  input  logic              en_i,
  input  bp_type_e          type_i,
  input  logic              vld_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              half_i,
  input  logic [W-1:0]      bp_i,
  output logic              hit_o
);
  localparam int MA_W = PAGE_W + WORD_W;

  logic [MA_W-1:0] maddr;
  logic            addr_eq;
  logic            half_eq;
  logic            match;

  assign maddr   = {page_i, word_i};
  assign addr_eq = (bp_i[MA_W-1:0] == maddr);
  assign half_eq = (bp_i[MA_W] == half_i);

  always_comb begin
    unique case (type_i)
      BPT_LOW:          match = addr_eq && half_eq;
      BPT_MID, BPT_ALL: match = addr_eq;
      default:          match = 1'b0;
    endcase
  end

  assign hit_o = en_i && vld_i && match;
endmodule

// File: rtl/bpm_pulse.sv
module bpm_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mclr_i,
  input  logic hit_i,
  input  logic irq_sel_i,
  output logic stop_o,
  output logic irq_o
);
  logic stop_q, irq_q, fire;

  assign fire = hit_i && !mclr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      stop_q <= fire && !irq_sel_i;
      irq_q  <= fire && irq_sel_i;
    end
  end

  assign stop_o = stop_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/bpm_unit.sv
module bpm_unit
  import bpm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 4,
  parameter int WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mclr_i,
  input  logic              bp_wr_en_i,
  input  logic [ADDR_W-1:0] bp_wr_data_i,
  input  logic              micro_sel_i,
  input  logic [1:0]        bp_type_i,
  input  logic              irq_sel_i,
  input  logic              mac_vld_i,
  input  logic              mac_fetch_i,
  input  logic              mac_store_i,
  input  logic [ADDR_W-1:0] mac_addr_i,
  input  logic              mic_vld_i,
  input  logic [PAGE_W-1:0] mic_page_i,
  input  logic [WORD_W-1:0] mic_word_i,
  input  logic              mic_half_i,
  output logic [ADDR_W-1:0] bp_addr_o,
  output logic              stop_o,
  output logic              irq_o
);
  bp_type_e          bp_type;
  logic [ADDR_W-1:0] bp_q;
  logic              mac_hit, mic_hit;

  assign bp_type = bp_type_e'(bp_type_i);

  bpm_addr_reg #(.W(ADDR_W)) i_reg (
    .clk_i, .rst_ni, .mclr_i,
    .wr_en_i   (bp_wr_en_i),
    .wr_data_i (bp_wr_data_i),
    .q_o       (bp_q)
  );

  bpm_macro_cmp #(.W(ADDR_W)) i_mac (
    .en_i    (!micro_sel_i),
    .type_i  (bp_type),
    .vld_i   (mac_vld_i),
    .fetch_i (mac_fetch_i),
    .store_i (mac_store_i),
    .addr_i  (mac_addr_i),
    .bp_i    (bp_q),
    .hit_o   (mac_hit)
  );

  bpm_micro_cmp #(.W(ADDR_W), .PAGE_W(PAGE_W), .WORD_W(WORD_W)) i_mic (
    .en_i   (micro_sel_i),
    .type_i (bp_type),
    .vld_i  (mic_vld_i),
    .page_i (mic_page_i),
    .word_i (mic_word_i),
    .half_i (mic_half_i),
    .bp_i   (bp_q),
    .hit_o  (mic_hit)
  );

  bpm_pulse i_pulse (
    .clk_i, .rst_ni, .mclr_i,
    .hit_i     (mac_hit || mic_hit),
    .irq_sel_i (irq_sel_i),
    .stop_o,
    .irq_o
  );

  assign bp_addr_o = bp_q;
endmodule

// File: rtl/bpm_unit_chk.sv
module bpm_unit_chk #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 4,
  parameter int WORD_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mclr_i,
  input logic              bp_wr_en_i,
  input logic [ADDR_W-1:0] bp_wr_data_i,
  input logic              micro_sel_i,
  input logic [1:0]        bp_type_i,
  input logic              irq_sel_i,
  input logic              mac_vld_i,
  input logic              mac_fetch_i,
  input logic              mac_store_i,
  input logic [ADDR_W-1:0] mac_addr_i,
  input logic              mic_vld_i,
  input logic [PAGE_W-1:0] mic_page_i,
  input logic [WORD_W-1:0] mic_word_i,
  input logic              mic_half_i,
  input logic [ADDR_W-1:0] bp_addr_o,
  input logic              stop_o,
  input logic              irq_o
);
  // R1
  wr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bp_wr_en_i && !mclr_i |=> bp_addr_o == $past(bp_wr_data_i));

  // R2
  mclr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mclr_i |=> bp_addr_o == '0 && !stop_o && !irq_o);

  // R4
  type_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bp_type_i == 2'b00 |=> !stop_o && !irq_o);

  // R5
  macro_any_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !micro_sel_i && bp_type_i == 2'b11 && mac_vld_i && mac_addr_i == bp_addr_o
    && !mclr_i && !irq_sel_i |=> stop_o);

  // R8
  no_strobe_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mac_vld_i && !mic_vld_i |=> !stop_o && !irq_o);

  // R9
  irq_not_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_sel_i |=> !stop_o);

  // R9
  excl_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(stop_o && irq_o));
endmodule

bind bpm_unit bpm_unit_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WORD_W(WORD_W)) i_chk (.*);

// File: tb/test_bpm_unit.sv
module test_bpm_unit;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic        stop;
    logic        irq;
    logic [15:0] bp;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mclr, wr_en, micro_sel, irq_sel;
  logic [15:0] wr_data, mac_addr;
  logic [1:0]  bp_type;
  logic        mac_vld, mac_fetch, mac_store;
  logic        mic_vld, mic_half;
  logic [3:0]  mic_page;
  logic [7:0]  mic_word;
  logic [15:0] bp_addr;
  logic        stop, irq;

  int          checks = 0;
  int          fails  = 0;
  bit          done   = 1'b0;
  logic [15:0] mirror = '0;
  exp_t        exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bpm_unit i_bpm_unit (
    .clk_i(clk), .rst_ni, .mclr_i(mclr), .bp_wr_en_i(wr_en), .bp_wr_data_i(wr_data),
    .micro_sel_i(micro_sel), .bp_type_i(bp_type), .irq_sel_i(irq_sel),
    .mac_vld_i(mac_vld), .mac_fetch_i(mac_fetch), .mac_store_i(mac_store),
    .mac_addr_i(mac_addr), .mic_vld_i(mic_vld), .mic_page_i(mic_page),
    .mic_word_i(mic_word), .mic_half_i(mic_half),
    .bp_addr_o(bp_addr), .stop_o(stop), .irq_o(irq)
  );

  task automatic clear_strobes();
    mclr = 0; wr_en = 0; wr_data = '0;
    mac_vld = 0; mac_fetch = 0; mac_store = 0; mac_addr = '0;
    mic_vld = 0; mic_page = '0; mic_word = '0; mic_half = 0;
  endtask

  // Model built from R2-R9; called after inputs for the cycle are set
  task automatic issue(input string tag);
    logic hit, kind;
    exp_t e;
    hit = 1'b0;
    if (!micro_sel && mac_vld) begin
      case (bp_type)
        2'b01:   kind = mac_fetch;
        2'b10:   kind = mac_store;
        2'b11:   kind = 1'b1;
        default: kind = 1'b0;
      endcase
      hit = kind && (mac_addr == mirror);
    end
    if (micro_sel && mic_vld) begin
      if (bp_type == 2'b01)   hit = (mirror[12:0] == {mic_half, mic_page, mic_word});
      else if (bp_type[1])    hit = (mirror[11:0] == {mic_page, mic_word});
    end
    hit = hit && !mclr;
    if (mclr)       mirror = '0;
    else if (wr_en) mirror = wr_data;
    e.stop = hit && !irq_sel;
    e.irq  = hit && irq_sel;
    e.bp   = mirror;
    e.tag  = tag;
    exp_q.push_back(e);
  endtask

  task automatic cfg(input logic m, input logic [1:0] t, input logic i);
    @(negedge clk); clear_strobes();
    micro_sel = m; bp_type = t; irq_sel = i;
    issue("cfg idle R8");
  endtask

  task automatic wr(input logic [15:0] d, input string tag);
    @(negedge clk); clear_strobes();
    wr_en = 1; wr_data = d;
    issue(tag);
  endtask

  task automatic mac(input logic f, input logic s, input logic [15:0] a, input string tag);
    @(negedge clk); clear_strobes();
    mac_vld = 1; mac_fetch = f; mac_store = s; mac_addr = a;
    issue(tag);
  endtask

  task automatic mic(input logic [3:0] p, input logic [7:0] w, input logic h, input string tag);
    @(negedge clk); clear_strobes();
    mic_vld = 1; mic_page = p; mic_word = w; mic_half = h;
    issue(tag);
  endtask

  // Monitor: outputs settle at the edge after the driving negedge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (stop !== e.stop || irq !== e.irq || bp_addr !== e.bp) begin
          fails++;
          $display("FAIL %s: stop/irq/bp got %0b/%0b/%h expected %0b/%0b/%h",
                   e.tag, stop, irq, bp_addr, e.stop, e.irq, e.bp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    clear_strobes();
    micro_sel = 0; bp_type = 2'b00; irq_sel = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    checks++;
    if (bp_addr !== '0 || stop !== 0 || irq !== 0) begin
      fails++;
      $display("FAIL R1 reset: got %h/%0b/%0b expected 0000/0/0", bp_addr, stop, irq);
    end

    wr(16'h1234, "R1 load");
    cfg(0, 2'b01, 0);
    mac(1, 0, 16'h1234, "R4 fetch hit");
    mac(0, 1, 16'h1234, "R4 store miss type01");
    mac(1, 0, 16'h1235, "R5 low bit mismatch");
    mac(1, 0, 16'h9234, "R5 high bit mismatch");
    cfg(0, 2'b10, 0);
    mac(0, 1, 16'h1234, "R4 store hit");
    mac(1, 0, 16'h1234, "R4 fetch miss type10");
    cfg(0, 2'b11, 0);
    mac(1, 0, 16'h1234, "R4 any fetch");
    mac(0, 1, 16'h1234, "R8 back-to-back store");
    mac(0, 0, 16'h1234, "R4 any plain");
    cfg(0, 2'b00, 0);
    mac(1, 1, 16'h1234, "R4 type00 none");
    cfg(0, 2'b11, 1);
    mac(1, 0, 16'h1234, "R9 irq instead of stop");
    cfg(0, 2'b11, 0);
    mic(4'h2, 8'h34, 1'b1, "R3 micro strobe in macro mode");

    wr(16'h1A5C, "R1 load micro");
    cfg(1, 2'b01, 0);
    mic(4'hA, 8'h5C, 1'b1, "R6 half match");
    mic(4'hA, 8'h5C, 1'b0, "R6 half mismatch");
    mic(4'hB, 8'h5C, 1'b1, "R6 page mismatch");
    mac(1, 0, 16'h1A5C, "R3 macro strobe in micro mode");
    cfg(1, 2'b10, 0);
    mic(4'hA, 8'h5C, 1'b0, "R7 half ignored lo");
    mic(4'hA, 8'h5C, 1'b1, "R7 half ignored hi");
    mic(4'hA, 8'h5D, 1'b0, "R7 word mismatch");
    wr(16'hFA5C, "R1 load upper");
    mic(4'hA, 8'h5C, 1'b0, "R7 bits 15:12 ignored");
    cfg(1, 2'b01, 0);
    mic(4'hA, 8'h5C, 1'b1, "R6 bits 15:13 ignored");
    cfg(1, 2'b11, 1);
    mic(4'hA, 8'h5C, 1'b0, "R9 micro irq");
    cfg(1, 2'b00, 0);
    mic(4'hA, 8'h5C, 1'b1, "R7 micro type00 none");
    cfg(1, 2'b10, 0);

    @(negedge clk); clear_strobes();
    mic_vld = 1; mic_page = 4'hA; mic_word = 8'h5C; wr_en = 1; wr_data = 16'h0000;
    issue("R8 compare uses old value");
    mic(4'hA, 8'h5C, 1'b0, "R8 new value applies");

    wr(16'h0A5C, "R1 reload");
    @(negedge clk); clear_strobes();
    mclr = 1; wr_en = 1; wr_data = 16'hFFFF;
    mic_vld = 1; mic_page = 4'hA; mic_word = 8'h5C;
    issue("R2 clear wins and suppresses");
    mic(4'h0, 8'h00, 1'b0, "R2 cleared register matches zero");

    @(negedge clk); clear_strobes(); issue("idle R8");
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule